// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Emulator

This block plays the device side of a single-wire temperature and humidity sensor. It watches a shared data line that an external pull-up keeps high when nobody drives it. The block itself can only pull the line low or let it go. When a host holds the line low long enough and then releases it, the block answers. It first waits a short turnaround, then gives a fixed low/high handshake. After that it sends a 40-bit frame in which each bit is a fixed low phase followed by a high phase whose length encodes the bit value.

The frame carries four measurement bytes taken from register inputs, followed by a checksum that the block computes itself. The four bytes are copied at the moment the start is accepted, so a transaction always carries one consistent snapshot. Every interval is given in microseconds and scaled by a clock-cycles-per-microsecond parameter. A small configuration can therefore shrink the millisecond-scale start pulse for simulation.

Top module: `hyg_wire_responder`

## Requirements
- R1: After reset the block leaves the line released (`pull_low_o` = 0) and `busy_o` = 0.
- R2: A start is accepted only when `line_i` has been low for at least HOST_START_US×CLKS_PER_US consecutive clock cycles while idle and then reads high. A shorter low, or a low broken by any high cycle, starts nothing.
- R3: Counting from the first cycle the line reads high after a valid start, the block keeps the line released for exactly TURNAROUND_US×CLKS_PER_US cycles.
- R4: The handshake is a pull-low of ACK_LOW_US×CLKS_PER_US cycles followed by a release of ACK_HIGH_US×CLKS_PER_US cycles.
- R5: Each data bit is a pull-low of BIT_LOW_US×CLKS_PER_US cycles followed by a release of ZERO_HIGH_US×CLKS_PER_US cycles for a 0 or ONE_HIGH_US×CLKS_PER_US cycles for a 1.
- R6: The frame is 40 bits sent most significant bit first. Its bytes are, in order, `hum_int_i`, `hum_frac_i`, `tmp_int_i`, `tmp_frac_i` and the checksum.
- R7: The checksum byte is the sum of the four measurement bytes modulo 256 (for example FF+FF+FF+FF gives FC).
- R8: The four bytes are captured at the cycle the start is accepted. Changes to the inputs during a transaction do not alter the frame being sent.
- R9: After the last bit the block pulls low for TAIL_LOW_US×CLKS_PER_US cycles, then releases the line. `busy_o` is high from the cycle after the start is accepted until that release, and it is low again on the first released cycle.
- R10: A new start pulse is accepted as soon as the block is idle again, with no minimum gap between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared data line |
| hum_int_i | input | 8 | Humidity integer byte |
| hum_frac_i | input | 8 | Humidity fraction byte |
| tmp_int_i | input | 8 | Temperature integer byte |
| tmp_frac_i | input | 8 | Temperature fraction byte |
| pull_low_o | output | 1 | 1 = drive the line low, 0 = release it |
| busy_o | output | 1 | A transaction is in progress |

## Verification
The bench models the line as a wired AND of host and device. It measures every phase length in cycles and decodes the frame from the high-phase widths. It probes the start threshold one cycle short and exactly at the limit. A detector with an off-by-one error would answer the short pulse or ignore the exact one. It also sends a long low that is split by one high cycle, which a design that does not restart its count on every high would wrongly accept. Byte sweeps whose sums wrap past 255 catch a checksum that is not truncated or is placed in the wrong slot. Inputs that change mid-transaction expose a design that shifts from live inputs instead of a snapshot. Back-to-back transactions show whether the block is ready again right after its tail low.

// File: rtl/hyg_pkg.sv
package hyg_pkg;

  localparam int FRAME_BITS = 40;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_TAIL
  } seq_state_t;

  // Checksum: byte sum truncated to eight bits.
  function automatic logic [BYTE_W-1:0] frame_sum(
    input logic [BYTE_W-1:0] a,
    input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] c,
    input logic [BYTE_W-1:0] d
  );
    logic [BYTE_W+1:0] wide;
    wide = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d};
    return wide[BYTE_W-1:0];
  endfunction

  // Frame assembly, first byte in the top bits (sent first).
  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic [BYTE_W-1:0] hi,
    input logic [BYTE_W-1:0] hf,
    input logic [BYTE_W-1:0] ti,
    input logic [BYTE_W-1:0] tf
  );
    return {hi, hf, ti, tf, frame_sum(hi, hf, ti, tf)};
  endfunction

  // States in which the device holds the line low.
  function automatic logic drives_low(input seq_state_t s);
    return (s == ST_ACK_LO) || (s == ST_BIT_LO) || (s == ST_TAIL);
  endfunction

endpackage

// File: rtl/hyg_start_detect.sv
module hyg_start_detect #(
  parameter int START_CYC = 900000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic line_i,
  output logic start_evt
);
  localparam int CW = $clog2(START_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(START_CYC);

  logic [CW-1:0] low_cnt;
  logic          armed;

  // Any high cycle, or a busy block, restarts the low-time count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (!enable || line_i) low_cnt <= '0;
    else if (low_cnt != LIMIT)  low_cnt <= low_cnt + 1'b1;
  end

  assign armed     = (low_cnt == LIMIT);
  assign start_evt = enable && line_i && armed;
endmodule

// File: rtl/hyg_phase_timer.sv
module hyg_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= load_val;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign expire = (remain == '0);
endmodule

// File: rtl/hyg_frame_seq.sv
module hyg_frame_seq
  import hyg_pkg::*;
#(
  parameter int TURN_C   = 650,
  parameter int ACK_LO_C = 4150,
  parameter int ACK_HI_C = 4350,
  parameter int BIT_LO_C = 2500,
  parameter int ZERO_C   = 1350,
  parameter int ONE_C    = 3500,
  parameter int TAIL_C   = 2500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_evt,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic                  pull_low,
  output logic                  busy,
  output logic [5:0]            bits_left
);
  localparam int M1   = (TURN_C > ACK_LO_C) ? TURN_C : ACK_LO_C;
  localparam int M2   = (ACK_HI_C > BIT_LO_C) ? ACK_HI_C : BIT_LO_C;
  localparam int M3   = (ZERO_C > ONE_C) ? ZERO_C : ONE_C;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int M3T  = (M3 > TAIL_C) ? M3 : TAIL_C;
  localparam int MAXC = (M12 > M3T) ? M12 : M3T;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [5:0] NBITS = 6'(FRAME_BITS);

  seq_state_t            state, nxt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  load, cap, shift, expire;
  logic [TW-1:0]         lval;

  hyg_phase_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(lval),
    .expire  (expire)
  );

  always_comb begin
    nxt   = state;
    load  = 1'b0;
    lval  = '0;
    cap   = 1'b0;
    shift = 1'b0;
    unique case (state)
      ST_IDLE: if (start_evt) begin
        nxt = ST_TURN; load = 1'b1; lval = TW'(TURN_C - 1); cap = 1'b1;
      end
      ST_TURN: if (expire) begin
        nxt = ST_ACK_LO; load = 1'b1; lval = TW'(ACK_LO_C - 1);
      end
      ST_ACK_LO: if (expire) begin
        nxt = ST_ACK_HI; load = 1'b1; lval = TW'(ACK_HI_C - 1);
      end
      ST_ACK_HI: if (expire) begin
        nxt = ST_BIT_LO; load = 1'b1; lval = TW'(BIT_LO_C - 1);
      end
      ST_BIT_LO: if (expire) begin
        nxt  = ST_BIT_HI;
        load = 1'b1;
        lval = shreg[FRAME_BITS-1] ? TW'(ONE_C - 1) : TW'(ZERO_C - 1);
      end
      ST_BIT_HI: if (expire) begin
        shift = 1'b1;
        load  = 1'b1;
        if (bits_left == 6'd1) begin
          nxt = ST_TAIL;   lval = TW'(TAIL_C - 1);
        end else begin
          nxt = ST_BIT_LO; lval = TW'(BIT_LO_C - 1);
        end
      end
      ST_TAIL: if (expire) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
    end else begin
      state <= nxt;
      if (cap) begin
        shreg     <= frame_in;
        bits_left <= NBITS;
      end else if (shift) begin
        shreg     <= {shreg[FRAME_BITS-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  assign pull_low = drives_low(state);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/hyg_wire_responder.sv
module hyg_wire_responder
  import hyg_pkg::*;
#(
  parameter int CLKS_PER_US   = 50,
  parameter int HOST_START_US = 18000,
  parameter int TURNAROUND_US = 13,
  parameter int ACK_LOW_US    = 83,
  parameter int ACK_HIGH_US   = 87,
  parameter int BIT_LOW_US    = 50,
  parameter int ZERO_HIGH_US  = 27,
  parameter int ONE_HIGH_US   = 70,
  parameter int TAIL_LOW_US   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic [7:0] hum_int_i,
  input  logic [7:0] hum_frac_i,
  input  logic [7:0] tmp_int_i,
  input  logic [7:0] tmp_frac_i,
  output logic       pull_low_o,
  output logic       busy_o
);
  localparam int START_CYC = HOST_START_US * CLKS_PER_US;
  localparam int LO_A      = ACK_LOW_US * CLKS_PER_US;
  localparam int LO_B      = BIT_LOW_US * CLKS_PER_US;
  localparam int LO_T      = TAIL_LOW_US * CLKS_PER_US;
  localparam int LO_AB     = (LO_A > LO_B) ? LO_A : LO_B;
  localparam int LO_MAX_CYC = (LO_AB > LO_T) ? LO_AB : LO_T;

  logic                  start_evt;
  logic [FRAME_BITS-1:0] frame_now;
  logic [5:0]            bits_left;

  assign frame_now = pack_frame(hum_int_i, hum_frac_i, tmp_int_i, tmp_frac_i);

  hyg_start_detect #(.START_CYC(START_CYC)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!busy_o),
    .line_i   (line_i),
    .start_evt(start_evt)
  );

  hyg_frame_seq #(
    .TURN_C  (TURNAROUND_US * CLKS_PER_US),
    .ACK_LO_C(LO_A),
    .ACK_HI_C(ACK_HIGH_US * CLKS_PER_US),
    .BIT_LO_C(LO_B),
    .ZERO_C  (ZERO_HIGH_US * CLKS_PER_US),
    .ONE_C   (ONE_HIGH_US * CLKS_PER_US),
    .TAIL_C  (LO_T)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .frame_in (frame_now),
    .pull_low (pull_low_o),
    .busy     (busy_o),
    .bits_left(bits_left)
  );
endmodule

// File: rtl/hyg_wire_chk.sv
module hyg_wire_chk #(
  parameter int LO_LIMIT = 4150
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_i,
  input logic       pull_low,
  input logic       busy,
  input logic       start_evt,
  input logic [5:0] bits_left
);
  logic [31:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_run <= '0;
    else if (pull_low) lo_run <= lo_run + 1;
    else               lo_run <= '0;
  end

  assert_pull_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy);

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_busy_only_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start_evt) && $past(line_i)));

  assert_turn_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !pull_low);

  assert_tail_before_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pull_low));

  assert_bit_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= 6'd40);

  assert_low_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= LO_LIMIT);
endmodule

bind hyg_wire_responder hyg_wire_chk #(.LO_LIMIT(LO_MAX_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_i   (line_i),
  .pull_low (pull_low_o),
  .busy     (busy_o),
  .start_evt(start_evt),
  .bits_left(bits_left)
);

// File: tb/hyg_wire_responder_tb.sv
module hyg_wire_responder_tb;
  localparam int CPU     = 2;
  localparam int START_C = 20 * CPU;
  localparam int TURN_C  = 3 * CPU;
  localparam int ALO_C   = 8 * CPU;
  localparam int AHI_C   = 9 * CPU;
  localparam int BLO_C   = 5 * CPU;
  localparam int ZERO_C  = 3 * CPU;
  localparam int ONE_C   = 7 * CPU;
  localparam int TAIL_C  = 5 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic [7:0] hi_b = '0, hf_b = '0, ti_b = '0, tf_b = '0;
  logic pull_low, busy, line;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign line = ~(pull_low | host_low);

  hyg_wire_responder #(
    .CLKS_PER_US(CPU), .HOST_START_US(20), .TURNAROUND_US(3),
    .ACK_LOW_US(8), .ACK_HIGH_US(9), .BIT_LOW_US(5),
    .ZERO_HIGH_US(3), .ONE_HIGH_US(7), .TAIL_LOW_US(5)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .hum_int_i(hi_b), .hum_frac_i(hf_b), .tmp_int_i(ti_b), .tmp_frac_i(tf_b),
    .pull_low_o(pull_low), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Counts consecutive samples at the current level; leaves on the first differing one.
  task automatic run_len(input logic level, output int n);
    n = 0;
    while (line === level && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic host_pulse(input int k);
    @(negedge clk) host_low = 1'b1;
    repeat (k) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic transaction(input logic [7:0] a, input logic [7:0] b,
                             input logic [7:0] c, input logic [7:0] d,
                             input bit mutate);
    logic [39:0] exp, got;
    logic [7:0]  sum;
    int n;
    sum = 8'((int'(a) + int'(b) + int'(c) + int'(d)) % 256);
    exp = {a, b, c, d, sum};
    got = '0;
    hi_b = a; hf_b = b; ti_b = c; tf_b = d;
    host_pulse(START_C);
    @(negedge clk);
    check(busy === 1'b1, "R9 busy after start", 64'(busy), 1);
    run_len(1'b1, n); check(n == TURN_C, "R3 turnaround", n, TURN_C);
    run_len(1'b0, n); check(n == ALO_C, "R4 ack low", n, ALO_C);
    if (mutate) begin
      hi_b = ~a; hf_b = a ^ 8'h5A; ti_b = ~c; tf_b = d + 8'd1;
    end
    run_len(1'b1, n); check(n == AHI_C, "R4 ack high", n, AHI_C);
    for (int i = 0; i < 40; i++) begin
      run_len(1'b0, n); check(n == BLO_C, "R5 bit low", n, BLO_C);
      run_len(1'b1, n);
      check(n == ONE_C || n == ZERO_C, "R5 bit high width", n, ONE_C);
      got = {got[38:0], (n == ONE_C)};
    end
    run_len(1'b0, n); check(n == TAIL_C, "R9 tail low", n, TAIL_C);
    check(busy === 1'b0 && line === 1'b1, "R9 idle after tail", 64'(busy), 0);
    check(got == exp, mutate ? "R8 snapshot frame" : "R6 frame order", got, exp);
    check(got[7:0] == sum, "R7 checksum", got[7:0], sum);
  endtask

  task automatic expect_no_start(input string req);
    int seen = 0;
    repeat (TURN_C + ALO_C + 4) begin
      @(negedge clk);
      if (busy !== 1'b0 || line !== 1'b1) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && pull_low === 1'b0, "R1 reset state", {busy, pull_low}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && line === 1'b1, "R1 idle after reset", 64'(busy), 0);

    // R2: one cycle short of the threshold
    host_pulse(START_C - 1);
    expect_no_start("R2 short pulse ignored");
    // R2: long low split by a single high cycle
    host_pulse(START_C - 2);
    host_pulse(3);
    expect_no_start("R2 broken pulse ignored");

    // R2/R6/R7: exact threshold and byte sweeps with wrapping sums
    transaction(8'h35, 8'h00, 8'h18, 8'h04, 1'b0);
    transaction(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    transaction(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++)
      transaction(8'(k * 37 + 1), 8'(k * 11 + 3), 8'(255 - k * 29), 8'(k * k * 5), 1'b0);
    // R8: inputs change mid-transaction
    transaction(8'hA5, 8'h3C, 8'h81, 8'h7E, 1'b1);
    // R10: back-to-back start right after idle
    transaction(8'h12, 8'h34, 8'h56, 8'h78, 1'b0);
    transaction(8'hC3, 8'h99, 8'hF0, 8'h0F, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule